// File: doc/BRIEF.md
# DDR2 Bank Command Sequencer

This block sits between a request scheduler and the command pins of a DDR2 SDRAM. Each request names a bank, a row and a column, and is either a read or a write. The block remembers which row is open in every bank. It works out the command sequence a request needs: a column command when the row is already open, an activate first when the bank is closed, or a single-bank precharge and then an activate when a different row is open. Each command is held back until the programmed minimum spacing since earlier commands has passed.

Commands leave on registered chip-select, row-strobe, column-strobe and write-enable outputs, together with a bank address and a shared row/column address. A data-phase start strobe marks the clock cycle in which the eight-beat burst for each read or write begins on the data bus. The block issues a close-all precharge once after reset, and again whenever the surrounding logic asks for one, for example after the memory's power-up initialization.

Top module: `ddr2_bank_seq`

## Requirements
- R1: After reset is released, the first command driven is a precharge of all banks. It appears in the cycle after the first rising clock edge at which reset is inactive, with address bit 10 high.
- R2: A one-cycle pulse on `close_all` causes one precharge-all. After it, every bank counts as closed, so the next access to any bank starts with an activate.
- R3: A request to a closed bank first issues an activate with the request's bank on `cmd_ba` and its row on `cmd_addr`. The read or write follows that activate.
- R4: A request whose row is already open in its bank issues no activate and no precharge. It goes straight to the column command, with the column on the low bits of `cmd_addr`, address bit 10 low and the bank on `cmd_ba`.
- R5: A request to a bank whose open row differs issues a single-bank precharge (address bit 10 low, that bank on `cmd_ba`), then an activate, then the column command. Rows open in other banks stay open.
- R6: A column command to a bank comes at least `cfg_trcd_m1`+1 cycles after that bank's activate. It comes exactly that many cycles later when nothing else delays it.
- R7: An activate to a bank comes at least `cfg_trp_m1`+1 cycles after a precharge of that bank or a precharge-all. It comes exactly that many cycles later when nothing else delays it.
- R8: An activate comes at least `cfg_trrd_m1`+1 cycles after an activate to a different bank. It comes exactly that many cycles later when that limit is the binding one.
- R9: Because a burst of eight beats takes four clocks, successive column commands are at least 4 cycles apart. A precharge or precharge-all comes at least 4 cycles after the last column command.
- R10: For a read issued in cycle t, `data_start` is high with `data_write` low in cycle t+`cfg_cas_lat`, for `cfg_cas_lat` values 2 to 7. `data_start` is high in no other cycle without a burst due.
- R11: For a write issued in cycle t, `data_start` and `data_write` are both high in cycle t+`cfg_cas_lat`-1.
- R12: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: activate 0011, read 0101, write 0100, precharge 0010. When no command is driven, all four are 1, including during reset. `req_ready` is high for exactly one cycle per request, in the cycle just before that request's column command appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_ready | output | 1 | Request accepted at the coming clock edge |
| close_all | input | 1 | Pulse: precharge all banks |
| cfg_cas_lat | input | CL_W | Read latency in clocks (2 to 7) |
| cfg_trcd_m1 | input | TIM_W | Activate-to-column spacing minus one |
| cfg_trp_m1 | input | TIM_W | Precharge-to-activate spacing minus one |
| cfg_trrd_m1 | input | TIM_W | Activate-to-activate spacing across banks minus one |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank address |
| cmd_addr | output | ADDR_W | Row or column address; bit 10 selects precharge-all |
| data_start | output | 1 | First cycle of a data burst |
| data_write | output | 1 | The burst starting now is a write |

## Verification
The bench builds the block with four banks, a 13-bit row and 4-bit timing fields. It programs an activate-to-column spacing of 3, a precharge-to-activate spacing of 4 and a wide activate-to-activate spacing of 7. With that wide spacing, the cross-bank limit is the one that holds back a second activate, so its exact value shows at the pins. The CAS latency is changed between 4, 5 and 2, so the write delay reaches its smallest value of one clock and the read and write strobes are seen at several offsets.

// File: rtl/ddr2_seq_pkg.sv
package ddr2_seq_pkg;

   // command chosen for the coming clock edge
   typedef enum logic [2:0] {
      SEQ_NONE,
      SEQ_ACT,
      SEQ_RD,
      SEQ_WR,
      SEQ_PRE,
      SEQ_PALL
   } seq_cmd_e;

   localparam int BURST_BEATS = 8;
   // a burst of eight beats on a double-rate bus lasts this many clocks
   localparam int COL_GAP     = BURST_BEATS / 2;
   // address bit that separates precharge-all from single-bank precharge
   localparam int PALL_BIT    = 10;

   // {cs_n, ras_n, cas_n, we_n}
   function automatic logic [3:0] seq_pins(seq_cmd_e c);
      logic [3:0] p;
      case (c)
         SEQ_ACT:  p = 4'b0011;
         SEQ_RD:   p = 4'b0101;
         SEQ_WR:   p = 4'b0100;
         SEQ_PRE,
         SEQ_PALL: p = 4'b0010;
         default:  p = 4'b1111;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/ddr2_row_tracker.sv
module ddr2_row_tracker #(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 14,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               act_en,
   input  logic                               pre_en,
   input  logic                               pall_en,
   input  logic [BANK_W-1:0]                  bank_sel,
   input  logic [ROW_W-1:0]                   row_in,
   output logic [NUM_BANKS-1:0]               open_vld,
   output logic [NUM_BANKS-1:0][ROW_W-1:0]    open_row
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_bank;
      assign hit_bank = (bank_sel == BANK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_vld[b] <= 1'b0;
            open_row[b] <= '0;
         end else if (pall_en || (pre_en && hit_bank)) begin
            open_vld[b] <= 1'b0;
         end else if (act_en && hit_bank) begin
            open_vld[b] <= 1'b1;
            open_row[b] <= row_in;
         end
      end
   end

endmodule

// File: rtl/ddr2_timing_guard.sv
module ddr2_timing_guard #(
   parameter int NUM_BANKS = 8,
   parameter int TIM_W     = 4,
   parameter int GAP       = 4,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int GAP_W    = $clog2(GAP + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  act_en,
   input  logic                  pre_en,
   input  logic                  pall_en,
   input  logic                  col_en,
   input  logic [BANK_W-1:0]     bank_sel,
   input  logic [TIM_W-1:0]      trcd_m1,
   input  logic [TIM_W-1:0]      trp_m1,
   input  logic [TIM_W-1:0]      trrd_m1,
   output logic [NUM_BANKS-1:0]  rcd_ok,
   output logic [NUM_BANKS-1:0]  rp_ok,
   output logic                  rrd_ok,
   output logic                  col_ok
);

   // per-bank down counters: zero means the spacing has elapsed
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [TIM_W-1:0] rcd_cnt;
      logic [TIM_W-1:0] rp_cnt;
      logic             hit_bank;
      assign hit_bank = (bank_sel == BANK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rcd_cnt <= '0;
         end else if (act_en && hit_bank) begin
            rcd_cnt <= trcd_m1;
         end else if (rcd_cnt != '0) begin
            rcd_cnt <= rcd_cnt - 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rp_cnt <= '0;
         end else if (pall_en || (pre_en && hit_bank)) begin
            rp_cnt <= trp_m1;
         end else if (rp_cnt != '0) begin
            rp_cnt <= rp_cnt - 1'b1;
         end
      end

      assign rcd_ok[b] = (rcd_cnt == '0);
      assign rp_ok[b]  = (rp_cnt == '0);
   end

   logic [TIM_W-1:0] rrd_cnt;
   logic [GAP_W-1:0] col_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rrd_cnt <= '0;
      end else if (act_en) begin
         rrd_cnt <= trrd_m1;
      end else if (rrd_cnt != '0) begin
         rrd_cnt <= rrd_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_cnt <= '0;
      end else if (col_en) begin
         col_cnt <= GAP_W'(GAP - 1);
      end else if (col_cnt != '0) begin
         col_cnt <= col_cnt - 1'b1;
      end
   end

   assign rrd_ok = (rrd_cnt == '0);
   assign col_ok = (col_cnt == '0);

endmodule

// File: rtl/ddr2_data_phase.sv
module ddr2_data_phase #(
   parameter int CL_W    = 3,
   localparam int MAX_CL = (1 << CL_W) - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_issue,
   input  logic            wr_issue,
   input  logic [CL_W-1:0] cas_lat,
   output logic            data_start,
   output logic            data_write
);

   // bit n is high n cycles after the command appeared on the pins
   logic [MAX_CL:0] rd_pipe;
   logic [MAX_CL:0] wr_pipe;
   logic [CL_W-1:0] wr_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pipe <= '0;
         wr_pipe <= '0;
      end else begin
         rd_pipe <= {rd_pipe[MAX_CL-1:0], rd_issue};
         wr_pipe <= {wr_pipe[MAX_CL-1:0], wr_issue};
      end
   end

   assign wr_lat     = cas_lat - 1'b1;
   assign data_write = wr_pipe[wr_lat];
   assign data_start = rd_pipe[cas_lat] | data_write;

endmodule

// File: rtl/ddr2_bank_seq.sv
module ddr2_bank_seq
   import ddr2_seq_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 14,
   parameter int COL_W     = 10,
   parameter int ADDR_W    = 14,
   parameter int TIM_W     = 4,
   parameter int CL_W      = 3,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [BANK_W-1:0]  req_bank,
   input  logic [ROW_W-1:0]   req_row,
   input  logic [COL_W-1:0]   req_col,
   output logic               req_ready,
   input  logic               close_all,
   input  logic [CL_W-1:0]    cfg_cas_lat,
   input  logic [TIM_W-1:0]   cfg_trcd_m1,
   input  logic [TIM_W-1:0]   cfg_trp_m1,
   input  logic [TIM_W-1:0]   cfg_trrd_m1,
   output logic               cmd_cs_n,
   output logic               cmd_ras_n,
   output logic               cmd_cas_n,
   output logic               cmd_we_n,
   output logic [BANK_W-1:0]  cmd_ba,
   output logic [ADDR_W-1:0]  cmd_addr,
   output logic               data_start,
   output logic               data_write
);

   localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << PALL_BIT;

   // parameter legality
   if (NUM_BANKS < 2 || NUM_BANKS > 8 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be 2, 4 or 8");
   end
   if (COL_W > PALL_BIT) begin : g_bad_col
      $error("COL_W must leave address bit 10 free");
   end
   if (ADDR_W <= PALL_BIT || ROW_W > ADDR_W) begin : g_bad_addr
      $error("ADDR_W must exceed 10 and hold a full row");
   end
   if (TIM_W < 1 || CL_W < 2) begin : g_bad_fields
      $error("timing fields need TIM_W >= 1 and CL_W >= 2");
   end

   seq_cmd_e                          nxt_cmd;
   logic                              pall_pend;
   logic [NUM_BANKS-1:0]              bank_open_vld;
   logic [NUM_BANKS-1:0][ROW_W-1:0]   bank_open_row;
   logic [NUM_BANKS-1:0]              rcd_ok;
   logic [NUM_BANKS-1:0]              rp_ok;
   logic                              rrd_ok;
   logic                              col_ok;
   logic                              tgt_open;
   logic                              tgt_hit;
   logic                              act_en;
   logic                              pre_en;
   logic                              pall_en;
   logic                              rd_en;
   logic                              wr_en;
   logic [ADDR_W-1:0]                 row_addr;
   logic [ADDR_W-1:0]                 col_addr;

   assign tgt_open = bank_open_vld[req_bank];
   assign tgt_hit  = (bank_open_row[req_bank] == req_row);

   // one command per cycle; close-all takes precedence over requests
   always_comb begin
      nxt_cmd = SEQ_NONE;
      if (pall_pend) begin
         if (col_ok) nxt_cmd = SEQ_PALL;
      end else if (req_valid) begin
         if (tgt_open && tgt_hit) begin
            if (col_ok && rcd_ok[req_bank]) nxt_cmd = req_write ? SEQ_WR : SEQ_RD;
         end else if (tgt_open) begin
            if (col_ok) nxt_cmd = SEQ_PRE;
         end else begin
            if (rp_ok[req_bank] && rrd_ok) nxt_cmd = SEQ_ACT;
         end
      end
   end

   assign act_en    = (nxt_cmd == SEQ_ACT);
   assign pre_en    = (nxt_cmd == SEQ_PRE);
   assign pall_en   = (nxt_cmd == SEQ_PALL);
   assign rd_en     = (nxt_cmd == SEQ_RD);
   assign wr_en     = (nxt_cmd == SEQ_WR);
   assign req_ready = rd_en | wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pall_pend <= 1'b1;
      end else if (close_all) begin
         pall_pend <= 1'b1;
      end else if (pall_en) begin
         pall_pend <= 1'b0;
      end
   end

   // address formatting
   if (ADDR_W > ROW_W) begin : g_row_pad
      assign row_addr = {{(ADDR_W - ROW_W){1'b0}}, req_row};
   end else begin : g_row_full
      assign row_addr = req_row;
   end
   assign col_addr = {{(ADDR_W - COL_W){1'b0}}, req_col};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= 4'b1111;
         cmd_ba   <= '0;
         cmd_addr <= '0;
      end else begin
         {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} <= seq_pins(nxt_cmd);
         case (nxt_cmd)
            SEQ_ACT: begin
               cmd_ba   <= req_bank;
               cmd_addr <= row_addr;
            end
            SEQ_RD, SEQ_WR: begin
               cmd_ba   <= req_bank;
               cmd_addr <= col_addr;
            end
            SEQ_PRE: begin
               cmd_ba   <= req_bank;
               cmd_addr <= '0;
            end
            SEQ_PALL: begin
               cmd_ba   <= '0;
               cmd_addr <= PALL_ADDR;
            end
            default: begin
               cmd_ba   <= '0;
               cmd_addr <= '0;
            end
         endcase
      end
   end

   ddr2_row_tracker #(
      .NUM_BANKS (NUM_BANKS),
      .ROW_W     (ROW_W)
   ) i_row_tracker (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_en   (act_en),
      .pre_en   (pre_en),
      .pall_en  (pall_en),
      .bank_sel (req_bank),
      .row_in   (req_row),
      .open_vld (bank_open_vld),
      .open_row (bank_open_row)
   );

   ddr2_timing_guard #(
      .NUM_BANKS (NUM_BANKS),
      .TIM_W     (TIM_W),
      .GAP       (COL_GAP)
   ) i_timing_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_en   (act_en),
      .pre_en   (pre_en),
      .pall_en  (pall_en),
      .col_en   (req_ready),
      .bank_sel (req_bank),
      .trcd_m1  (cfg_trcd_m1),
      .trp_m1   (cfg_trp_m1),
      .trrd_m1  (cfg_trrd_m1),
      .rcd_ok   (rcd_ok),
      .rp_ok    (rp_ok),
      .rrd_ok   (rrd_ok),
      .col_ok   (col_ok)
   );

   ddr2_data_phase #(
      .CL_W (CL_W)
   ) i_data_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_issue   (rd_en),
      .wr_issue   (wr_en),
      .cas_lat    (cfg_cas_lat),
      .data_start (data_start),
      .data_write (data_write)
   );

endmodule

// File: rtl/ddr2_seq_checker.sv
module ddr2_seq_checker #(
   parameter int NUM_BANKS = 8,
   parameter int ROW_W     = 14,
   parameter int ADDR_W    = 14,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             req_ready,
   input logic                             cmd_cs_n,
   input logic                             cmd_ras_n,
   input logic                             cmd_cas_n,
   input logic                             cmd_we_n,
   input logic [BANK_W-1:0]                cmd_ba,
   input logic [ADDR_W-1:0]                cmd_addr,
   input logic [NUM_BANKS-1:0]             open_vld,
   input logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row
);

   logic is_act, is_col, is_pre, is_pall;
   logic seen_cmd;

   assign is_act  = !cmd_cs_n && !cmd_ras_n &&  cmd_cas_n &&  cmd_we_n;
   assign is_col  = !cmd_cs_n &&  cmd_ras_n && !cmd_cas_n;
   assign is_pre  = !cmd_cs_n && !cmd_ras_n &&  cmd_cas_n && !cmd_we_n && !cmd_addr[10];
   assign is_pall = !cmd_cs_n && !cmd_ras_n &&  cmd_cas_n && !cmd_we_n &&  cmd_addr[10];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seen_cmd <= 1'b0;
      else if (!cmd_cs_n) seen_cmd <= 1'b1;
   end

   assert_first_is_pall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!seen_cmd && !cmd_cs_n) |-> is_pall);

   assert_pall_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      is_pall |-> (open_vld == '0));

   assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> (open_vld[cmd_ba] && open_row[cmd_ba] == cmd_addr[ROW_W-1:0]));

   assert_col_open_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> open_vld[cmd_ba]);

   assert_pre_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> !open_vld[cmd_ba]);

   assert_col_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> (!$past(is_col) && !$past(is_col, 2) && !$past(is_col, 3)));

   assert_ready_to_col_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> is_col);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_cs_n |-> (cmd_ras_n && cmd_cas_n && cmd_we_n));

endmodule

bind ddr2_bank_seq ddr2_seq_checker #(
   .NUM_BANKS (NUM_BANKS),
   .ROW_W     (ROW_W),
   .ADDR_W    (ADDR_W)
) i_ddr2_seq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .cmd_cs_n  (cmd_cs_n),
   .cmd_ras_n (cmd_ras_n),
   .cmd_cas_n (cmd_cas_n),
   .cmd_we_n  (cmd_we_n),
   .cmd_ba    (cmd_ba),
   .cmd_addr  (cmd_addr),
   .open_vld  (bank_open_vld),
   .open_row  (bank_open_row)
);

// File: tb/test_ddr2_bank_seq.sv
`timescale 1ns/1ps
module test_ddr2_bank_seq;

   localparam int NB     = 4;
   localparam int ROW_W  = 13;
   localparam int COL_W  = 10;
   localparam int ADDR_W = 14;
   localparam int TIM_W  = 4;
   localparam int CL_W   = 3;
   localparam int BW     = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [BW-1:0]     req_bank = '0;
   logic [ROW_W-1:0]  req_row = '0;
   logic [COL_W-1:0]  req_col = '0;
   logic              req_ready;
   logic              close_all = 1'b0;
   logic [CL_W-1:0]   cfg_cas_lat = 3'd4;
   logic [TIM_W-1:0]  cfg_trcd_m1 = 4'd2;
   logic [TIM_W-1:0]  cfg_trp_m1 = 4'd3;
   logic [TIM_W-1:0]  cfg_trrd_m1 = 4'd6;
   logic              cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
   logic [BW-1:0]     cmd_ba;
   logic [ADDR_W-1:0] cmd_addr;
   logic              data_start, data_write;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ddr2_bank_seq #(
      .NUM_BANKS (NB), .ROW_W (ROW_W), .COL_W (COL_W),
      .ADDR_W (ADDR_W), .TIM_W (TIM_W), .CL_W (CL_W)
   ) i_ddr2_bank_seq (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write), .req_bank (req_bank),
      .req_row (req_row), .req_col (req_col), .req_ready (req_ready),
      .close_all (close_all), .cfg_cas_lat (cfg_cas_lat),
      .cfg_trcd_m1 (cfg_trcd_m1), .cfg_trp_m1 (cfg_trp_m1), .cfg_trrd_m1 (cfg_trrd_m1),
      .cmd_cs_n (cmd_cs_n), .cmd_ras_n (cmd_ras_n), .cmd_cas_n (cmd_cas_n),
      .cmd_we_n (cmd_we_n), .cmd_ba (cmd_ba), .cmd_addr (cmd_addr),
      .data_start (data_start), .data_write (data_write)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic bit p_act();  return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b0011; endfunction
   function automatic bit p_rd();   return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b0101; endfunction
   function automatic bit p_wr();   return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b0100; endfunction
   function automatic bit p_pre();  return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b0010 && !cmd_addr[10]; endfunction
   function automatic bit p_pall(); return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b0010 && cmd_addr[10]; endfunction

   // ---------------- pin monitor: spacing rules and data-phase timing
   int  last_act[NB];
   int  last_pre[NB];
   bit  m_open[NB];
   int  last_act_any = -100;
   int  last_act_bank = -1;
   int  last_col = -100;
   bit  exp_start[64];
   bit  exp_wr[64];

   initial begin
      for (int i = 0; i < NB; i++) begin
         last_act[i] = -100;
         last_pre[i] = -100;
         m_open[i]   = 1'b0;
      end
      for (int i = 0; i < 64; i++) begin
         exp_start[i] = 1'b0;
         exp_wr[i]    = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int b;
         int slot;
         int cl;
         b    = int'(cmd_ba);
         slot = cyc % 64;
         cl   = int'(cfg_cas_lat);
         if (data_start || exp_start[slot]) begin
            check(data_start == exp_start[slot] && data_write == exp_wr[slot],
                  (exp_wr[slot] || data_write) ? "R11 write data start" : "R10 read data start",
                  {data_start, data_write}, {exp_start[slot], exp_wr[slot]});
         end
         exp_start[slot] = 1'b0;
         exp_wr[slot]    = 1'b0;
         if (p_act()) begin
            check(cyc - last_pre[b] >= int'(cfg_trp_m1) + 1, "R7 precharge to activate",
                  cyc - last_pre[b], int'(cfg_trp_m1) + 1);
            if (last_act_bank >= 0 && last_act_bank != b)
               check(cyc - last_act_any >= int'(cfg_trrd_m1) + 1, "R8 activate to activate",
                     cyc - last_act_any, int'(cfg_trrd_m1) + 1);
            check(!m_open[b], "R3 activate on closed bank", m_open[b], 0);
            m_open[b] = 1'b1;
            last_act[b] = cyc;
            last_act_any = cyc;
            last_act_bank = b;
         end
         if (p_pre() || p_pall()) begin
            check(cyc - last_col >= 4, "R9 column to precharge", cyc - last_col, 4);
            if (p_pall()) begin
               for (int i = 0; i < NB; i++) begin
                  m_open[i] = 1'b0;
                  last_pre[i] = cyc;
               end
            end else begin
               m_open[b] = 1'b0;
               last_pre[b] = cyc;
            end
         end
         if (p_rd() || p_wr()) begin
            check(m_open[b] && cyc - last_act[b] >= int'(cfg_trcd_m1) + 1,
                  "R6 activate to column", cyc - last_act[b], int'(cfg_trcd_m1) + 1);
            check(cyc - last_col >= 4, "R9 column to column", cyc - last_col, 4);
            last_col = cyc;
            if (p_rd()) begin
               exp_start[(cyc + cl) % 64] = 1'b1;
               exp_wr[(cyc + cl) % 64]    = 1'b0;
            end else begin
               exp_start[(cyc + cl - 1) % 64] = 1'b1;
               exp_wr[(cyc + cl - 1) % 64]    = 1'b1;
            end
         end
      end
   end

   // ---------------- helpers
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_access(input bit wr, input int b, input int row, input int col,
                            input int exp_pre, input int exp_act,
                            output int act_c, output int col_c, output int pre_c);
      int  n_act = 0;
      int  n_pre = 0;
      int  n_rdy = 0;
      bit  done  = 0;
      int  guard = 0;
      act_c = -1; col_c = -1; pre_c = -1;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr;
      req_bank = BW'(b); req_row = ROW_W'(row); req_col = COL_W'(col);
      #1;
      if (req_ready) n_rdy++;
      while (!done && guard < 100) begin
         @(negedge clk);
         guard++;
         if (p_act() && int'(cmd_ba) == b) begin
            n_act++; act_c = cyc;
            check(int'(cmd_addr) == row, "R3 activate row address", int'(cmd_addr), row);
         end
         if (p_pre() && int'(cmd_ba) == b) begin
            n_pre++; pre_c = cyc;
         end
         if (p_rd() || p_wr()) begin
            done = 1; col_c = cyc;
            check(int'(cmd_ba) == b, "R4 column bank", int'(cmd_ba), b);
            check(int'(cmd_addr) == col, "R4 column address with bit 10 low", int'(cmd_addr), col);
            check(p_wr() == wr, "R12 column command code", p_wr(), wr);
            req_valid = 1'b0;
         end else begin
            #1;
            if (req_ready) n_rdy++;
         end
      end
      check(done, "R12 request completes", done, 1);
      check(n_act == exp_act, exp_act != 0 ? "R3 activate count" : "R4 no activate on hit", n_act, exp_act);
      check(n_pre == exp_pre, "R5 single-bank precharge count", n_pre, exp_pre);
      check(n_rdy == 1, "R12 ready pulses per request", n_rdy, 1);
   endtask

   // ---------------- scenarios
   task automatic t_reset();
      idle(3);
      check({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b1111 && !data_start,
            "R12 deselect during reset", {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 15);
      rst_n = 1'b1;
      @(negedge clk);
      check(p_pall(), "R1 first command is precharge-all",
            {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_addr[10]}, 5'b00101);
   endtask

   task automatic t_cold_then_hit();
      int a, c, p;
      idle(6);
      do_access(1'b0, 0, 5, 8, 0, 1, a, c, p);
      check(c - a == int'(cfg_trcd_m1) + 1, "R6 exact activate to read", c - a, int'(cfg_trcd_m1) + 1);
      do_access(1'b1, 0, 5, 16, 0, 0, a, c, p);
   endtask

   task automatic t_cross_bank();
      int a1, a2, c, p;
      idle(10);
      do_access(1'b0, 1, 7, 3, 0, 1, a1, c, p);
      do_access(1'b0, 2, 1, 4, 0, 1, a2, c, p);
      check(a2 - a1 == int'(cfg_trrd_m1) + 1, "R8 exact activate spacing", a2 - a1, int'(cfg_trrd_m1) + 1);
   endtask

   task automatic t_row_miss();
      int a, c, p;
      idle(12);
      do_access(1'b0, 0, 9, 2, 1, 1, a, c, p);
      check(a - p == int'(cfg_trp_m1) + 1, "R7 exact precharge to activate", a - p, int'(cfg_trp_m1) + 1);
      do_access(1'b1, 1, 7, 5, 0, 0, a, c, p);   // R5: other banks kept their rows
      do_access(1'b0, 2, 1, 6, 0, 0, a, c, p);
   endtask

   task automatic t_back_to_back();
      int a, c1, c2, p;
      idle(8);
      do_access(1'b0, 1, 7, 10, 0, 0, a, c1, p);
      do_access(1'b1, 1, 7, 11, 0, 0, a, c2, p);
      check(c2 - c1 == 4, "R9 exact column spacing", c2 - c1, 4);
   endtask

   task automatic t_close_all();
      int pc = -1;
      int a, c, p;
      idle(8);
      close_all = 1'b1;
      @(negedge clk);
      close_all = 1'b0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (p_pall()) begin
            pc = cyc;
            break;
         end
      end
      check(pc >= 0, "R2 precharge-all after close request", pc >= 0, 1);
      do_access(1'b0, 1, 7, 0, 0, 1, a, c, p);
      check(a - pc == int'(cfg_trp_m1) + 1, "R7 exact precharge-all to activate", a - pc, int'(cfg_trp_m1) + 1);
      do_access(1'b0, 2, 1, 1, 0, 1, a, c, p);   // R2: bank 2 also closed
   endtask

   task automatic t_latencies();
      int a, c, p;
      idle(12);
      cfg_cas_lat = 3'd5;
      do_access(1'b0, 1, 7, 20, 0, 0, a, c, p);
      do_access(1'b1, 1, 7, 21, 0, 0, a, c, p);
      idle(12);
      cfg_cas_lat = 3'd2;
      do_access(1'b1, 2, 1, 22, 0, 0, a, c, p);
      do_access(1'b0, 2, 1, 23, 0, 0, a, c, p);
      idle(12);
   endtask

   initial begin
      t_reset();
      t_cold_then_hit();
      t_cross_bank();
      t_row_miss();
      t_back_to_back();
      t_close_all();
      t_latencies();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired, all requirements incomplete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule